// File: doc/BRIEF.md
# Source Clock Prescaler with Hold and Pass-Through

This block divides a source clock by a small integer before the result fans out to a group of downstream channel dividers. A 3-bit select field chooses a ratio from 1 to 6. Ratio 1 passes the source clock straight through. Ratios 2 to 6 come from a counter-driven state machine. When the ratio is odd, the high phase is the longer one.

Two extra controls change what reaches the output. The hold control parks the output at a low level, with no clock edges. The pass-through control routes the source clock to the output with no division, whatever the select field or hold control say. Pass-through is separate from ratio 1: only ratio 1 with the pass-through control off is in conflict with bypassed downstream dividers. The block raises a configuration-error flag for that combination and for out-of-range select codes.

The state machine has five states:
- `ST_IDLE`: entered at reset, output low.
- `ST_HIGH` and `ST_LOW`: the two phases of a divided period.
- `ST_THRU`: ratio 1 is latched.
- `ST_HOLD`: the output is parked low.

Every exit from `ST_LOW`, `ST_THRU` or `ST_IDLE` is a period boundary. At a boundary the machine moves to `ST_HOLD` if hold is requested. Otherwise it latches the current ratio and moves to `ST_THRU` (ratio 1) or to `ST_HIGH` (ratio 2 to 6). The other transitions are:
- `ST_HIGH` to `ST_LOW` when the high-phase count ends.
- `ST_LOW` to a boundary when the low-phase count ends.
- `ST_HOLD` to a boundary once hold is released.

Top module: `clk_prescaler`

## Requirements
- R1: Select codes 2 to 6 give an output period of exactly that many source-clock cycles.
- R2: The high phase lasts ceil(r/2) source cycles and the low phase lasts floor(r/2), where r is the active ratio.
- R3: Select code 1 gives ratio 1, and the output then follows the source clock level.
- R4: Select codes 0 and 7 are treated as ratio 6 and drive cfg_err to 1.
- R5: While hold_en is 1, the output is held low from the next period boundary onward. Once hold_en is released, division resumes at the selected ratio.
- R6: While thru_en is 1, the output follows the source clock, regardless of the select code and of hold_en.
- R7: cfg_err is 1 when the select code is 1, thru_en is 0 and any chan_byp bit is 1. It is 0 for codes 2 to 6 with bypassed channels, and for code 1 when thru_en is 1.
- R8: A new select value takes effect only at the next period boundary, so the period in progress completes at its old ratio.
- R9: During reset the divided output is low and the phase counter is cleared. The first high phase begins at the first source edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | SEL_W (3) | Ratio select code; 1 to 6 are valid |
| hold_en | input | 1 | Park the output low at the next period boundary |
| thru_en | input | 1 | Route the source clock to the output, undivided |
| chan_byp | input | NUM_CH (4) | Bypass flags of the downstream channel dividers |
| clk_out | output | 1 | Prescaled clock |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The bench builds the block with its default parameters: a 3-bit select field, a maximum ratio of 6 and four downstream bypass flags. With a 3-bit field, both out-of-range codes (0 and 7) can be reached alongside all six legal ratios. Every odd ratio is measured, which tests the uneven high and low split. Four flags let the bench set a single interior bypass bit and show that any one bit alone is enough to raise the error.

// File: rtl/presc_pkg.sv
package presc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_THRU,
        ST_HOLD
    } presc_state_e;

endpackage

// File: rtl/presc_decode.sv
module presc_decode #(
    parameter int SEL_W     = 3,
    parameter int MAX_RATIO = 6,
    parameter int NUM_CH    = 4,
    parameter int RAT_W     = 3
) (
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              thru_en,
    input  logic [NUM_CH-1:0] chan_byp,
    output logic [RAT_W-1:0]  ratio,
    output logic              cfg_err
);
    localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(MAX_RATIO);
    localparam logic [RAT_W-1:0] MAX_RAT  = RAT_W'(MAX_RATIO);
    localparam logic [RAT_W-1:0] ONE_RAT  = RAT_W'(1);

    logic code_bad;

    always_comb begin
        code_bad = (div_sel == '0) || (div_sel > MAX_CODE);
        ratio    = code_bad ? MAX_RAT : RAT_W'(div_sel);
        cfg_err  = code_bad || ((ratio == ONE_RAT) && !thru_en && (|chan_byp));
    end

    always_comb begin
        if (div_sel == '0) begin
            // R4
            bad_code_chk: assert (ratio == MAX_RAT && cfg_err);
        end
    end

endmodule

// File: rtl/presc_fsm.sv
module presc_fsm
    import presc_pkg::*;
#(
    parameter int MAX_RATIO = 6,
    parameter int RAT_W     = 3
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic [RAT_W-1:0] ratio_in,
    input  logic             hold_en,
    output logic             div_q,
    output logic             thru_act
);
    localparam logic [RAT_W-1:0] MAX_RAT = RAT_W'(MAX_RATIO);
    localparam logic [RAT_W-1:0] ONE_RAT = RAT_W'(1);

    presc_state_e     state, state_nx;
    logic [RAT_W-1:0] cur_ratio, ratio_nx;
    logic [RAT_W-1:0] cnt, cnt_nx;
    logic [RAT_W-1:0] hlen, llen;
    logic [RAT_W:0]   half_up;
    logic             boundary;

    always_comb begin
        half_up = ({1'b0, cur_ratio} + 1'b1) >> 1;
        hlen    = half_up[RAT_W-1:0];
        llen    = cur_ratio - hlen;
    end

    always_comb begin
        state_nx = state;
        ratio_nx = cur_ratio;
        cnt_nx   = cnt;
        boundary = 1'b0;
        unique case (state)
            ST_IDLE, ST_THRU: boundary = 1'b1;
            ST_HOLD:          boundary = !hold_en;
            ST_HIGH: begin
                if (cnt == hlen - ONE_RAT) begin
                    state_nx = ST_LOW;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + ONE_RAT;
                end
            end
            ST_LOW: begin
                if (cnt == llen - ONE_RAT) boundary = 1'b1;
                else                       cnt_nx   = cnt + ONE_RAT;
            end
            default: state_nx = ST_IDLE;
        endcase
        if (boundary) begin
            cnt_nx = '0;
            if (hold_en) begin
                state_nx = ST_HOLD;
            end else begin
                ratio_nx = ratio_in;
                state_nx = (ratio_in == ONE_RAT) ? ST_THRU : ST_HIGH;
            end
        end
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_ratio <= MAX_RAT;
            cnt       <= '0;
        end else begin
            state     <= state_nx;
            cur_ratio <= ratio_nx;
            cnt       <= cnt_nx;
        end
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= (state_nx == ST_HIGH);
    end

    assign thru_act = (state == ST_THRU);

    // R8
    ratio_hold_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == ST_LOW) |-> $stable(cur_ratio));

    // R2
    hi_cnt_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == ST_HIGH) |-> (cnt < hlen));

    // R5
    hold_low_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == ST_HOLD) |-> !div_q);

    // R3
    thru_ratio_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        (state == ST_THRU) |-> (cur_ratio == ONE_RAT));

endmodule

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
    parameter int SEL_W     = 3,
    parameter int MAX_RATIO = 6,
    parameter int NUM_CH    = 4
) (
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              hold_en,
    input  logic              thru_en,
    input  logic [NUM_CH-1:0] chan_byp,
    output logic              clk_out,
    output logic              cfg_err
);
    localparam int RAT_W = $clog2(MAX_RATIO + 1);

    logic [RAT_W-1:0] ratio;
    logic             div_q;
    logic             thru_act;

    presc_decode #(
        .SEL_W     (SEL_W),
        .MAX_RATIO (MAX_RATIO),
        .NUM_CH    (NUM_CH),
        .RAT_W     (RAT_W)
    ) u_decode (
        .div_sel  (div_sel),
        .thru_en  (thru_en),
        .chan_byp (chan_byp),
        .ratio    (ratio),
        .cfg_err  (cfg_err)
    );

    presc_fsm #(
        .MAX_RATIO (MAX_RATIO),
        .RAT_W     (RAT_W)
    ) u_fsm (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .ratio_in (ratio),
        .hold_en  (hold_en),
        .div_q    (div_q),
        .thru_act (thru_act)
    );

    assign clk_out = (thru_en || thru_act) ? clk_src : div_q;

    always_comb begin
        if (!rst_n && !thru_en) begin
            // R9
            reset_low_chk: assert (!clk_out);
        end
    end

endmodule

// File: tb/clk_prescaler_tb.sv
`timescale 1ns/1ps
module clk_prescaler_tb;

    logic       clk_src = 1'b0;
    logic       rst_n   = 1'b0;
    logic [2:0] div_sel = 3'd2;
    logic       hold_en = 1'b0;
    logic       thru_en = 1'b0;
    logic [3:0] chan_byp = 4'b0000;
    logic       clk_out;
    logic       cfg_err;

    int total = 0;
    int bad   = 0;

    always #4 clk_src = ~clk_src;

    clk_prescaler u_dut (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .hold_en  (hold_en),
        .thru_en  (thru_en),
        .chan_byp (chan_byp),
        .clk_out  (clk_out),
        .cfg_err  (cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic samp_lo(output logic v);
        @(negedge clk_src); #1; v = clk_out;
    endtask

    task automatic samp_hi(output logic v);
        @(posedge clk_src); #2; v = clk_out;
    endtask

    // Sync to a rising output, optionally change the select there,
    // then count high and low samples up to the next rise.
    task automatic measure(input logic [2:0] nsel, input bit chg,
                           output int hi, output int lo);
        logic prev, s;
        samp_lo(prev);
        for (int i = 0; i < 60; i++) begin
            samp_lo(s);
            if (!prev && s) break;
            prev = s;
        end
        if (chg) div_sel = nsel;
        hi = 1; lo = 0;
        for (int i = 0; i < 60; i++) begin
            samp_lo(s);
            if (s && lo > 0) break;
            if (s) hi++; else lo++;
        end
    endtask

    task automatic t_reset();
        logic v;
        samp_lo(v); check("R9 reset low phase", v, 0);
        samp_hi(v); check("R9 reset high phase", v, 0);
        @(negedge clk_src); rst_n = 1'b1;
        samp_lo(v); check("R9 first high after release", v, 1);
    endtask

    task automatic t_ratios();
        int hi, lo;
        for (int r = 2; r <= 6; r++) begin
            div_sel = 3'(r);
            measure(3'd0, 1'b0, hi, lo);
            measure(3'd0, 1'b0, hi, lo);
            check("R1 period", hi + lo, r);
            check("R2 high phase", hi, (r + 1) / 2);
        end
    endtask

    task automatic t_bad_codes();
        int hi, lo;
        div_sel = 3'd0; #1;
        check("R4 err code0", cfg_err, 1);
        measure(3'd0, 1'b0, hi, lo);
        measure(3'd0, 1'b0, hi, lo);
        check("R4 code0 period", hi + lo, 6);
        div_sel = 3'd7; #1;
        check("R4 err code7", cfg_err, 1);
        measure(3'd0, 1'b0, hi, lo);
        measure(3'd0, 1'b0, hi, lo);
        check("R4 code7 period", hi + lo, 6);
        check("R4 code7 high", hi, 3);
    endtask

    task automatic t_thru_ratio();
        logic v;
        div_sel = 3'd1;
        repeat (8) @(posedge clk_src);
        for (int i = 0; i < 3; i++) begin
            samp_lo(v); check("R3 follows src low", v, 0);
            samp_hi(v); check("R3 follows src high", v, 1);
        end
        #1 check("R7 code1 no bypass no err", cfg_err, 0);
    endtask

    task automatic t_errors();
        div_sel = 3'd1; thru_en = 1'b0; chan_byp = 4'b0100; #1;
        check("R7 code1 with bypassed channel", cfg_err, 1);
        div_sel = 3'd3; #1;
        check("R7 code3 with bypassed channel", cfg_err, 0);
        div_sel = 3'd1; thru_en = 1'b1; #1;
        check("R7 code1 with pass-through", cfg_err, 0);
        thru_en = 1'b0; chan_byp = 4'b0000; div_sel = 3'd2; #1;
    endtask

    task automatic t_thru_pin();
        logic v;
        div_sel = 3'd4; hold_en = 1'b1; thru_en = 1'b1;
        repeat (10) @(posedge clk_src);
        for (int i = 0; i < 3; i++) begin
            samp_lo(v); check("R6 pass-through low", v, 0);
            samp_hi(v); check("R6 pass-through high", v, 1);
        end
        thru_en = 1'b0; hold_en = 1'b0;
    endtask

    task automatic t_hold();
        logic v;
        int ones, hi, lo;
        div_sel = 3'd3;
        measure(3'd0, 1'b0, hi, lo);
        hold_en = 1'b1;
        repeat (8) @(posedge clk_src);
        ones = 0;
        for (int i = 0; i < 12; i++) begin
            samp_lo(v); ones += int'(v);
            samp_hi(v); ones += int'(v);
        end
        check("R5 hold output low", ones, 0);
        hold_en = 1'b0;
        measure(3'd0, 1'b0, hi, lo);
        check("R5 resume period", hi + lo, 3);
    endtask

    task automatic t_change();
        int hi, lo;
        div_sel = 3'd6;
        measure(3'd0, 1'b0, hi, lo);
        measure(3'd2, 1'b1, hi, lo);
        check("R8 period in progress high", hi, 3);
        check("R8 period in progress total", hi + lo, 6);
        measure(3'd0, 1'b0, hi, lo);
        check("R8 new ratio period", hi + lo, 2);
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ratios();
        t_bad_codes();
        t_thru_ratio();
        t_errors();
        t_thru_pin();
        t_hold();
        t_change();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule